// File: doc/BRIEF.md
# Reconfigurable Instruction Dispatch Arbiter

This block stands between instruction memory and a fixed-function core processor. It looks only at the opcode field of each fetched 32-bit word. Ordinary words go to the core unchanged. Three reserved opcodes mark reconfigurable work: partial set, complete set and execute. For these, the block hands a microcode address and an operation kind to a microcoded reconfigurable unit, together with a one-cycle start pulse.

While the unit works, the block holds the core in place. It feeds the core a fixed no-operation word through its issue multiplexer. It raises an occupy flag so that the memory arbiter favours the unit, and it stops accepting fetched words. When the unit reports completion, the block clears the flag and resumes normal issue with the next fetched word, which may be of either kind.

Top module: `rid_arbiter`

## Requirements
- R1: After a synchronous active-low reset, core_valid, start_op and occupy are 0, fetch_ready is 1, core_instr equals the no-operation word (default 32'h6000_0000), op_kind is 2'b00 and mc_addr is 0.
- R2: A fetched word accepted while idle (fetch_valid and fetch_ready both 1), whose opcode bits [31:26] are not reserved, appears unchanged on core_instr with core_valid=1 in the next cycle.
- R3: Only opcode bits [31:26] classify a word. 6'h3A is partial set, 6'h3B is complete set and 6'h3C is execute. Every other value, 6'h3D included, is ordinary, whatever the remaining bits hold.
- R4: In the cycle after a reconfigurable word is accepted, start_op is 1 for exactly one cycle. In that same cycle mc_addr carries bits [21:0] of the word, and op_kind carries 2'b01 for partial set, 2'b10 for complete set or 2'b11 for execute. Both hold their values until the next start.
- R5: occupy rises in the same cycle as start_op and stays 1 until the cycle after end_op is sampled. fetch_ready is 0 whenever occupy is 1, so a word offered during that time is not consumed.
- R6: In every cycle that occupy is 1, core_valid is 1 and core_instr is the no-operation word.
- R7: end_op sampled while occupy is 1 drops occupy in the next cycle, with core_valid=0. From then on the next fetched word issues normally, whether it is ordinary or reconfigurable.
- R8: end_op sampled while occupy is 0 has no effect: occupy stays 0 and ordinary issue continues.
- R9: With no word accepted and occupy 0, the next cycle shows core_valid=0 and core_instr equal to the no-operation word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_valid | input | 1 | A fetched instruction word is offered |
| fetch_instr | input | 32 | Fetched instruction word |
| fetch_ready | output | 1 | Arbiter can take a word this cycle |
| core_valid | output | 1 | core_instr carries a word for the core |
| core_instr | output | 32 | Word issued to the core (original or no-operation) |
| start_op | output | 1 | One-cycle start pulse to the reconfigurable unit |
| mc_addr | output | 22 | Microcode address for the unit |
| op_kind | output | 2 | Operation kind: 01 partial set, 10 complete set, 11 execute |
| end_op | input | 1 | Completion from the reconfigurable unit |
| occupy | output | 1 | Reconfigurable operation in progress; memory priority to the unit |

## Verification
The assertions check, on every cycle, the properties that hold locally. start_op never lasts more than one cycle and is always paired with occupy. occupy only rises together with a start. occupy always drops after end_op. Each occupied cycle shows the no-operation word. A plain word accepted one cycle earlier appears unchanged on core_instr. The bench scenarios cover what needs a known input history. These are: correct classification of boundary opcodes with arbitrary low bits, the exact microcode address and kind, a word offered while occupied and then issued only after release, end_op arriving in the start cycle or while idle, and back-to-back reconfigurable operations. All of these are compared each clock against a behavioural model.

// File: rtl/rid_pkg.sv
// Package: shared encodings for the reconfigurable instruction dispatch arbiter.
// Assumes the opcode field occupies the top bits of the instruction word.
package rid_pkg;

    // Operation kind handed to the reconfigurable unit
    typedef enum logic [1:0] {
        KIND_NONE  = 2'b00,
        KIND_PSET  = 2'b01,
        KIND_CSET  = 2'b10,
        KIND_EXEC  = 2'b11
    } rkind_t;

    localparam int OPC_W = 6;

    // Reserved opcode values selecting reconfigurable work
    localparam logic [OPC_W-1:0] OPC_PSET = 6'h3A;
    localparam logic [OPC_W-1:0] OPC_CSET = 6'h3B;
    localparam logic [OPC_W-1:0] OPC_EXEC = 6'h3C;

endpackage

// File: rtl/rid_decode.sv
// Module: partial opcode decoder.
// Classifies a word using the opcode field alone. It returns KIND_NONE for
// ordinary words. Purely combinational.
module rid_decode
    import rid_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output rkind_t           kind,
    output logic             is_reconf
);

    // Map reserved opcodes onto operation kinds
    always_comb begin
        unique case (opcode)
            OPC_PSET: kind = KIND_PSET;
            OPC_CSET: kind = KIND_CSET;
            OPC_EXEC: kind = KIND_EXEC;
            default:  kind = KIND_NONE;
        endcase
    end

    // Any kind other than none routes the word to the reconfigurable unit
    always_comb is_reconf = (kind != KIND_NONE);

endmodule

// File: rtl/rid_ctrl.sv
// Module: reconfigurable operation controller.
// Tracks whether a reconfigurable operation is in progress. It issues the
// start pulse and latches the microcode address and kind. Assumes the parent
// only offers 'accept' while 'busy' is low.
module rid_ctrl
    import rid_pkg::*;
#(
    parameter int AW = 22
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          is_reconf,
    input  rkind_t        kind,
    input  logic [AW-1:0] addr_in,
    input  logic          end_op,
    output logic          busy,
    output logic          start_op,
    output logic [AW-1:0] mc_addr,
    output rkind_t        op_kind
);

    logic launch;

    // A launch is an accepted reconfigurable word
    always_comb launch = accept && is_reconf;

    // Busy flag: set on launch, cleared when completion arrives
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy <= 1'b0;
        else if (launch)
            busy <= 1'b1;
        else if (busy && end_op)
            busy <= 1'b0;
    end

    // Start pulse: high only in the cycle after a launch
    always_ff @(posedge clk) begin
        if (!rst_n)
            start_op <= 1'b0;
        else
            start_op <= launch;
    end

    // Hand-over registers: address and kind held until the next launch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mc_addr <= '0;
            op_kind <= KIND_NONE;
        end else if (launch) begin
            mc_addr <= addr_in;
            op_kind <= kind;
        end
    end

    // R4: start is a single-cycle pulse
    a_r4_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        start_op |=> !start_op);

    // R5: a start always comes with occupancy
    a_r5_start_occupied: assert property (@(posedge clk) disable iff (!rst_n)
        start_op |-> busy);

    // R5: occupancy only begins together with a start
    a_r5_rise_with_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> start_op);

    // R7: completion while busy releases the unit next cycle
    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && end_op) |=> !busy);

    // R4: a start always carries a real operation kind
    a_r4_kind_valid: assert property (@(posedge clk) disable iff (!rst_n)
        start_op |-> (op_kind != KIND_NONE));

endmodule

// File: rtl/rid_issue.sv
// Module: core issue multiplexer.
// Registers the word presented to the core. It picks either the fetched word
// or the fixed no-operation word that holds the core during reconfigurable
// work.
module rid_issue #(
    parameter int          IW      = 32,
    parameter logic [IW-1:0] EMU_NOP = 32'h6000_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          is_reconf,
    input  logic [IW-1:0] instr_in,
    input  logic          busy,
    input  logic          end_op,
    output logic          core_valid,
    output logic [IW-1:0] core_instr
);

    typedef enum logic [1:0] {
        SEL_IDLE,
        SEL_PASS,
        SEL_EMUL
    } sel_t;

    sel_t sel;

    // Pick the source for the next issued word
    always_comb begin
        if (busy)
            sel = end_op ? SEL_IDLE : SEL_EMUL;
        else if (accept)
            sel = is_reconf ? SEL_EMUL : SEL_PASS;
        else
            sel = SEL_IDLE;
    end

    // Issue register feeding the core
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_valid <= 1'b0;
            core_instr <= EMU_NOP;
        end else begin
            unique case (sel)
                SEL_PASS: begin
                    core_valid <= 1'b1;
                    core_instr <= instr_in;
                end
                SEL_EMUL: begin
                    core_valid <= 1'b1;
                    core_instr <= EMU_NOP;
                end
                default: begin
                    core_valid <= 1'b0;
                    core_instr <= EMU_NOP;
                end
            endcase
        end
    end

    // R2: an accepted plain word reaches the core unchanged one cycle later
    a_r2_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !is_reconf && !busy) |=> (core_valid && core_instr == $past(instr_in)));

    // R6: the core sees only the no-operation word while the unit is busy
    a_r6_hold_core: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (core_valid && core_instr == EMU_NOP));

endmodule

// File: rtl/rid_arbiter.sv
// Module: reconfigurable instruction dispatch arbiter (top).
// Partially decodes fetched words. It sends ordinary ones to the core and
// starts the reconfigurable unit for reserved opcodes, holding the core with
// no-operation words until the unit signals completion. Assumes fetch holds
// an offered word until fetch_ready is seen.
module rid_arbiter
    import rid_pkg::*;
#(
    parameter int            IW      = 32,
    parameter int            AW      = 22,
    parameter logic [IW-1:0] EMU_NOP = 32'h6000_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fetch_valid,
    input  logic [IW-1:0] fetch_instr,
    output logic          fetch_ready,
    output logic          core_valid,
    output logic [IW-1:0] core_instr,
    output logic          start_op,
    output logic [AW-1:0] mc_addr,
    output logic [1:0]    op_kind,
    input  logic          end_op,
    output logic          occupy
);

    localparam int OPC_LSB = IW - OPC_W;

    logic   busy;
    logic   accept;
    logic   is_reconf;
    rkind_t kind;
    rkind_t kind_q;

    // Take a word only while no reconfigurable operation is running
    always_comb fetch_ready = !busy;
    always_comb accept      = fetch_valid && fetch_ready;
    always_comb occupy      = busy;
    always_comb op_kind     = kind_q;

    rid_decode u_decode (
        .opcode    (fetch_instr[IW-1:OPC_LSB]),
        .kind      (kind),
        .is_reconf (is_reconf)
    );

    rid_ctrl #(.AW(AW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .is_reconf (is_reconf),
        .kind      (kind),
        .addr_in   (fetch_instr[AW-1:0]),
        .end_op    (end_op),
        .busy      (busy),
        .start_op  (start_op),
        .mc_addr   (mc_addr),
        .op_kind   (kind_q)
    );

    rid_issue #(.IW(IW), .EMU_NOP(EMU_NOP)) u_issue (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .is_reconf  (is_reconf),
        .instr_in   (fetch_instr),
        .busy       (busy),
        .end_op     (end_op),
        .core_valid (core_valid),
        .core_instr (core_instr)
    );

    // R5: no word is taken while occupied
    a_r5_no_take_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (occupy && fetch_valid) |=> (!start_op));

endmodule

// File: tb/sim_rid_arbiter.sv
`timescale 1ns/1ps
module sim_rid_arbiter;

    localparam logic [31:0] NOP = 32'h6000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_instr = '0;
    logic        fetch_ready;
    logic        core_valid;
    logic [31:0] core_instr;
    logic        start_op;
    logic [21:0] mc_addr;
    logic [1:0]  op_kind;
    logic        end_op = 1'b0;
    logic        occupy;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    // reference model state
    logic        m_busy = 1'b0, m_cv = 1'b0, m_st = 1'b0;
    logic [31:0] m_ci = NOP;
    logic [21:0] m_addr = '0;
    logic [1:0]  m_kind = 2'b00;
    logic        cmp_on = 1'b0;

    always #2 clk = ~clk;

    rid_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_instr(fetch_instr),
        .fetch_ready(fetch_ready), .core_valid(core_valid), .core_instr(core_instr),
        .start_op(start_op), .mc_addr(mc_addr), .op_kind(op_kind), .end_op(end_op),
        .occupy(occupy)
    );

    function automatic logic [1:0] kind_of(input logic [31:0] w);
        case (w[31:26])
            6'h3A:   return 2'b01;
            6'h3B:   return 2'b10;
            6'h3C:   return 2'b11;
            default: return 2'b00;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // behavioural reference, updated at each rising edge
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_busy <= 0; m_cv <= 0; m_ci <= NOP; m_st <= 0; m_addr <= '0; m_kind <= 2'b00;
        end else begin
            m_st <= 0;
            if (m_busy) begin
                m_cv <= !end_op; m_ci <= NOP;
                if (end_op) m_busy <= 0;
            end else if (fetch_valid) begin
                if (kind_of(fetch_instr) != 2'b00) begin
                    m_busy <= 1; m_st <= 1; m_addr <= fetch_instr[21:0];
                    m_kind <= kind_of(fetch_instr); m_cv <= 1; m_ci <= NOP;
                end else begin
                    m_cv <= 1; m_ci <= fetch_instr;
                end
            end else begin
                m_cv <= 0; m_ci <= NOP;
            end
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (cmp_on) begin
            string tg;
            tg = m_busy ? "R6" : (m_cv ? "R2" : "R9");
            check(core_valid === m_cv && core_instr === m_ci, tg,
                  {31'd0, core_valid, core_instr}, {31'd0, m_cv, m_ci});
            check(start_op === m_st, "R4", start_op, m_st);
            check(mc_addr === m_addr && op_kind === m_kind, "R4",
                  {op_kind, mc_addr}, {m_kind, m_addr});
            check(occupy === m_busy && fetch_ready === !m_busy, "R5",
                  {occupy, fetch_ready}, {m_busy, !m_busy});
        end
    end

    // watchdog
    initial begin
        #200000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic give(input logic [31:0] w);
        @(negedge clk); fetch_valid = 1; fetch_instr = w; end_op = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); fetch_valid = 0; end_op = 0;
        end
    endtask

    task automatic finish_op;
        @(negedge clk); fetch_valid = 0; end_op = 1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(!core_valid && !start_op && !occupy && fetch_ready && core_instr == NOP
              && op_kind == 2'b00 && mc_addr == 0, "R1",
              {start_op, occupy, fetch_ready, core_valid, core_instr}, {4'b0010, NOP});
        cmp_on = 1;

        // R2 plain words
        give(32'h0123_4567); give(32'hDEAD_BEEF); give(32'h0000_0000); idle(1);

        // R3 near-miss opcode 3D with low bits set is ordinary
        give(32'hF7FF_FFFF);
        @(negedge clk); fetch_valid = 0;
        check(core_instr == 32'hF7FF_FFFF && !occupy, "R3", core_instr, 32'hF7FF_FFFF);

        // R4 partial set, with R5 word offered while busy
        give(32'hE800_0000 | 32'h0012_345 | 32'h03C0_0000);
        @(negedge clk); fetch_valid = 1; fetch_instr = 32'h1111_2222;
        check(start_op && mc_addr == 22'h01_2345 && op_kind == 2'b01, "R4",
              {op_kind, mc_addr}, {2'b01, 22'h01_2345});
        @(negedge clk); @(negedge clk);
        check(occupy && core_instr == NOP && core_valid, "R6", core_instr, NOP);
        finish_op;
        idle(1);
        check(!occupy && !core_valid, "R7", occupy, 0);
        // held word now issues
        give(32'h1111_2222); idle(1);
        check(core_instr == 32'h1111_2222, "R5", core_instr, 32'h1111_2222);

        // R8 end_op while idle
        @(negedge clk); end_op = 1; fetch_valid = 0;
        give(32'h0BAD_F00D); idle(1);
        check(!occupy && core_instr == 32'h0BAD_F00D, "R8", core_instr, 32'h0BAD_F00D);

        // R3 complete set, end_op in the start cycle
        give(32'hEC3F_FFFF);
        @(negedge clk); fetch_valid = 0; end_op = 1;
        check(op_kind == 2'b10 && mc_addr == 22'h3F_FFFF, "R3", op_kind, 2'b10);
        idle(1);
        check(!occupy, "R7", occupy, 0);

        // R7 execute right after, then back-to-back set
        give(32'hF000_0ABC); idle(3); finish_op;
        give(32'hE800_0001); idle(2); finish_op;
        check(op_kind == 2'b01 && mc_addr == 22'h1, "R4", {op_kind, mc_addr}, {2'b01, 22'h1});
        give(32'h2222_3333); idle(3);

        // mixed pattern sweep
        for (int i = 0; i < 40; i++) begin
            logic [31:0] w;
            w = {6'(i * 7 + 50), 26'(i * 32'h9E37)};
            give(w);
            if (kind_of(w) != 2'b00) begin idle(2); finish_op; end
        end
        idle(4);
        cmp_on = 0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule